// File: doc/BRIEF.md
# Accumulator Execute Unit with Skip Evaluation

This block is the execute stage of an 8-bit accumulator machine. Each cycle it may accept one operation with its operands: the accumulator, a memory or immediate byte, a second immediate byte, the low nibble of the B pointer, a bit index, a bit-source select and the incoming carry and half-carry flags. It computes the new accumulator or memory byte, the next flag values, and a skip signal. The skip signal tells the sequencer to throw away the instruction that follows.

Conditional operations never branch. Two groups give skip with opposite sense. In the "run next only if" group (equality, inequality, greater-than and bit tests), skip is raised when the condition fails. In the "skip when zero" group (masked zero test and decrement), skip is raised when the result is zero. One compare looks only at the low nibble of the pointer register.

Results are captured in a registered output stage. A two-state controller tracks whether that stage holds a live result. The states are ST_IDLE, where nothing is presented, and ST_HOLD, where one result is presented for a cycle. The transitions are:
- ACCEPT: ST_IDLE to ST_HOLD, taken when in_valid is high.
- CHAIN: ST_HOLD to ST_HOLD, taken when in_valid is high.
- DRAIN: ST_HOLD to ST_IDLE, taken when in_valid is low.
- WAIT: ST_IDLE to ST_IDLE, taken when in_valid is low.

Top module: `acc_exec_unit`

## Requirements
- R1: While rst_n is low, out_valid, skip_out, wr_acc and wr_mem are 0, and the controller is in ST_IDLE.
- R2: The result of an operation accepted with in_valid high is presented one clock later, with out_valid high for exactly that cycle. When out_valid is low, skip_out, wr_acc and wr_mem are 0.
- R3: Op code 0 (plain add) gives res_acc = (acc_in + opnd_in) mod 256 and sets wr_acc. It leaves c_out and hc_out equal to c_in and hc_in.
- R4: Op code 1 (add with carry) gives res_acc = low 8 bits of acc_in + opnd_in + c_in and sets wr_acc. c_out is the carry out of bit 7 and hc_out is the carry out of bit 3 of that same sum.
- R5: Op code 2 (subtract with carry) gives res_acc = low 8 bits of acc_in + ~opnd_in + c_in and sets wr_acc. c_out is the carry out of bit 7 of that sum, so 1 means no borrow. hc_out is the carry out of bit 3.
- R6: Op codes 3, 4 and 5 write acc_in AND, OR and XOR opnd_in (in that order) to res_acc and set wr_acc.
- R7: Op code 6 writes nothing and raises skip_out exactly when (acc_in AND imm_in) is zero.
- R8: Op codes 7 (equal), 9 (not equal) and 10 (unsigned greater than) compare acc_in with opnd_in. They write nothing and raise skip_out exactly when the relation does not hold.
- R9: Op code 8 compares opnd_in with imm_in, writes nothing, and raises skip_out exactly when the two are unequal.
- R10: Op code 11 compares breg_lo_in with imm_in bits 3:0, writes nothing, and raises skip_out exactly when they are equal.
- R11: Op code 12 gives res_mem = (opnd_in − 1) mod 256 and sets wr_mem. It raises skip_out exactly when that new value is 0.
- R12: Op codes 13 and 14 give res_mem = opnd_in with bit bit_sel forced to 1 (op 13) or to 0 (op 14). All other bits are kept, and wr_mem is set.
- R13: Op code 15 writes nothing. It selects bit bit_sel of acc_in when bit_src is 0, or of opnd_in when bit_src is 1, and raises skip_out exactly when that bit is 0.
- R14: Every op code other than 1 and 2 passes c_in and hc_in through unchanged. skip_out is 0 for op codes 0 to 5, 13 and 14. Where wr_acc is 0, res_acc equals acc_in. Where wr_mem is 0, res_mem equals opnd_in. wr_acc and wr_mem are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_in | input | 4 | Operation code (see requirements) |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Memory or immediate operand |
| imm_in | input | 8 | Second immediate (zero test, memory compare, nibble compare) |
| breg_lo_in | input | 4 | Low nibble of the B pointer |
| bit_sel | input | 3 | Bit index for bit operations |
| bit_src | input | 1 | Bit test source: 0 accumulator, 1 operand |
| c_in | input | 1 | Current carry flag |
| hc_in | input | 1 | Current half-carry flag |
| out_valid | output | 1 | Registered result is live |
| res_acc | output | 8 | New accumulator value |
| res_mem | output | 8 | New memory byte |
| wr_acc | output | 1 | Accumulator should be written |
| wr_mem | output | 1 | Memory byte should be written |
| c_out | output | 1 | Next carry flag |
| hc_out | output | 1 | Next half-carry flag |
| skip_out | output | 1 | Discard the next instruction |

## Verification
If the controller state is wrong, out_valid is wrong in the cycle after the mismatch. Strobes would then leak while idle, or a result would be held for a second cycle. Both show up in the very next sample. A wrong carry-in path or a wrong bit-3 tap shows up as a bad c_out or hc_out on the first operand pair that crosses the bit-7 or bit-3 boundary. For that reason the directed cases use 0x00, 0xFF, 0x0F/0x01 and borrow pairs. An inverted skip sense in either group flips skip_out for every operand of that op code, so a single equal and a single unequal pair expose it one cycle after issue.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    typedef enum logic [3:0] {
        OP_SUM   = 4'd0,
        OP_SUMC  = 4'd1,
        OP_DIFC  = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_TSTZ  = 4'd6,
        OP_EQ    = 4'd7,
        OP_EQMI  = 4'd8,
        OP_NE    = 4'd9,
        OP_GT    = 4'd10,
        OP_NIBNE = 4'd11,
        OP_DECSZ = 4'd12,
        OP_SETB  = 4'd13,
        OP_CLRB  = 4'd14,
        OP_TSTB  = 4'd15
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hold_st_e;

endpackage

// File: rtl/acc_arith.sv
module acc_arith
    import acc_exec_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   m,
    input  logic            c_in,
    input  logic            hc_in,
    output logic [DW-1:0]   sum,
    output logic            c_o,
    output logic            hc_o
);
    localparam int NW = DW / 2;

    logic [DW-1:0] m_eff;
    logic          cin;
    logic          upd;
    logic [DW:0]   full;
    logic [NW:0]   low;

    // subtraction adds the inverted operand; carry-in only for the flag forms
    always_comb begin
        m_eff = (op == OP_DIFC) ? ~m : m;
        upd   = (op == OP_SUMC) || (op == OP_DIFC);
        cin   = upd ? c_in : 1'b0;
        full  = {1'b0, a} + {1'b0, m_eff} + {{DW{1'b0}}, cin};
        low   = {1'b0, a[NW-1:0]} + {1'b0, m_eff[NW-1:0]} + {{NW{1'b0}}, cin};
        sum   = full[DW-1:0];
        c_o   = upd ? full[DW] : c_in;
        hc_o  = upd ? low[NW]  : hc_in;
    end
endmodule

// File: rtl/acc_cond.sv
module acc_cond
    import acc_exec_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e               op,
    input  logic [DW-1:0]         a,
    input  logic [DW-1:0]         m,
    input  logic [DW-1:0]         imm,
    input  logic [DW/2-1:0]       b_lo,
    output logic [DW-1:0]         logic_res,
    output logic                  skip
);
    localparam int NW = DW / 2;

    always_comb begin
        unique case (op)
            OP_AND:  logic_res = a & m;
            OP_OR:   logic_res = a | m;
            OP_XOR:  logic_res = a ^ m;
            default: logic_res = a;
        endcase
    end

    // "run next only if" group skips on a false test; zero test skips on zero
    always_comb begin
        unique case (op)
            OP_TSTZ:  skip = ((a & imm) == '0);
            OP_EQ:    skip = (a != m);
            OP_EQMI:  skip = (m != imm);
            OP_NE:    skip = (a == m);
            OP_GT:    skip = !(a > m);
            OP_NIBNE: skip = (b_lo == imm[NW-1:0]);
            default:  skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_bitops.sv
module acc_bitops
    import acc_exec_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = $clog2(DW)
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   m,
    input  logic [BW-1:0]   sel,
    input  logic            src_mem,
    output logic [DW-1:0]   mem_res,
    output logic            skip
);
    logic [DW-1:0] mask;
    logic [DW-1:0] dec;
    logic [DW-1:0] tsrc;

    always_comb begin
        mask = '0;
        mask[sel] = 1'b1;
        dec  = m - {{(DW-1){1'b0}}, 1'b1};
        tsrc = src_mem ? m : a;
    end

    always_comb begin
        unique case (op)
            OP_DECSZ: begin
                mem_res = dec;
                skip    = (dec == '0);
            end
            OP_SETB: begin
                mem_res = m | mask;
                skip    = 1'b0;
            end
            OP_CLRB: begin
                mem_res = m & ~mask;
                skip    = 1'b0;
            end
            OP_TSTB: begin
                mem_res = m;
                skip    = !tsrc[sel];
            end
            default: begin
                mem_res = m;
                skip    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int DW = 8,
    parameter int NW = DW / 2,
    parameter int BW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op_in,
    input  logic [DW-1:0]   acc_in,
    input  logic [DW-1:0]   opnd_in,
    input  logic [DW-1:0]   imm_in,
    input  logic [NW-1:0]   breg_lo_in,
    input  logic [BW-1:0]   bit_sel,
    input  logic            bit_src,
    input  logic            c_in,
    input  logic            hc_in,
    output logic            out_valid,
    output logic [DW-1:0]   res_acc,
    output logic [DW-1:0]   res_mem,
    output logic            wr_acc,
    output logic            wr_mem,
    output logic            c_out,
    output logic            hc_out,
    output logic            skip_out
);
    alu_op_e       op;
    hold_st_e      state, state_nxt;

    logic [DW-1:0] ar_sum, lg_res, bt_mem;
    logic          ar_c, ar_hc, cd_skip, bt_skip;

    logic [DW-1:0] acc_n, mem_n;
    logic          wra_n, wrm_n;

    logic [DW-1:0] acc_q, mem_q;
    logic          wra_q, wrm_q, c_q, hc_q, skip_q;

    assign op = alu_op_e'(op_in);

    acc_arith #(.DW(DW)) u_arith (
        .op(op), .a(acc_in), .m(opnd_in), .c_in(c_in), .hc_in(hc_in),
        .sum(ar_sum), .c_o(ar_c), .hc_o(ar_hc)
    );

    acc_cond #(.DW(DW)) u_cond (
        .op(op), .a(acc_in), .m(opnd_in), .imm(imm_in), .b_lo(breg_lo_in),
        .logic_res(lg_res), .skip(cd_skip)
    );

    acc_bitops #(.DW(DW), .BW(BW)) u_bits (
        .op(op), .a(acc_in), .m(opnd_in), .sel(bit_sel), .src_mem(bit_src),
        .mem_res(bt_mem), .skip(bt_skip)
    );

    // destination select
    always_comb begin
        unique case (op)
            OP_SUM, OP_SUMC, OP_DIFC: begin
                acc_n = ar_sum;
                wra_n = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                acc_n = lg_res;
                wra_n = 1'b1;
            end
            default: begin
                acc_n = acc_in;
                wra_n = 1'b0;
            end
        endcase
        wrm_n = (op == OP_DECSZ) || (op == OP_SETB) || (op == OP_CLRB);
        mem_n = bt_mem;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: ACCEPT, CHAIN, DRAIN, WAIT
    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_nxt = in_valid ? ST_HOLD : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            mem_q  <= '0;
            wra_q  <= 1'b0;
            wrm_q  <= 1'b0;
            c_q    <= 1'b0;
            hc_q   <= 1'b0;
            skip_q <= 1'b0;
        end else if (in_valid) begin
            acc_q  <= acc_n;
            mem_q  <= mem_n;
            wra_q  <= wra_n;
            wrm_q  <= wrm_n;
            c_q    <= ar_c;
            hc_q   <= ar_hc;
            skip_q <= cd_skip | bt_skip;
        end
    end

    assign out_valid = (state == ST_HOLD);
    assign res_acc   = acc_q;
    assign res_mem   = mem_q;
    assign c_out     = c_q;
    assign hc_out    = hc_q;
    assign wr_acc    = out_valid & wra_q;
    assign wr_mem    = out_valid & wrm_q;
    assign skip_out  = out_valid & skip_q;

endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
    parameter int DW = 8,
    parameter int BW = $clog2(DW)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [3:0]      op_in,
    input logic [BW-1:0]   bit_sel,
    input logic            c_in,
    input logic            hc_in,
    input logic            out_valid,
    input logic [DW-1:0]   res_mem,
    input logic            wr_acc,
    input logic            wr_mem,
    input logic            c_out,
    input logic            hc_out,
    input logic            skip_out
);
    // R2
    issue_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!skip_out && !wr_acc && !wr_mem));

    // R14
    flag_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_in != 4'd1 && op_in != 4'd2)
        |=> (c_out == $past(c_in) && hc_out == $past(hc_in)));

    // R14
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_in <= 4'd5 || op_in == 4'd13 || op_in == 4'd14))
        |=> !skip_out);

    // R14
    one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_acc, wr_mem}));

    // R12
    set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_in == 4'd13) |=> res_mem[$past(bit_sel)]);

    // R12
    clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_in == 4'd14) |=> !res_mem[$past(bit_sel)]);

endmodule

bind acc_exec_unit acc_exec_chk #(.DW(DW), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
    .bit_sel(bit_sel), .c_in(c_in), .hc_in(hc_in), .out_valid(out_valid),
    .res_mem(res_mem), .wr_acc(wr_acc), .wr_mem(wr_mem), .c_out(c_out),
    .hc_out(hc_out), .skip_out(skip_out)
);

// File: tb/test_acc_exec_unit.sv
module test_acc_exec_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op_in = '0;
    logic [7:0] acc_in = '0, opnd_in = '0, imm_in = '0;
    logic [3:0] breg_lo_in = '0;
    logic [2:0] bit_sel = '0;
    logic       bit_src = 1'b0, c_in = 1'b0, hc_in = 1'b0;
    logic       out_valid, wr_acc, wr_mem, c_out, hc_out, skip_out;
    logic [7:0] res_acc, res_mem;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    acc_exec_unit i_acc_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
        .acc_in(acc_in), .opnd_in(opnd_in), .imm_in(imm_in),
        .breg_lo_in(breg_lo_in), .bit_sel(bit_sel), .bit_src(bit_src),
        .c_in(c_in), .hc_in(hc_in), .out_valid(out_valid), .res_acc(res_acc),
        .res_mem(res_mem), .wr_acc(wr_acc), .wr_mem(wr_mem), .c_out(c_out),
        .hc_out(hc_out), .skip_out(skip_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string op2tag(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4, 5: return "R6";
            6: return "R7";
            7, 9, 10: return "R8";
            8: return "R9";
            11: return "R10";
            12: return "R11";
            13, 14: return "R12";
            default: return "R13";
        endcase
    endfunction

    // expected {acc, mem, wra, wrm, c, hc, skip} from the requirements
    function automatic logic [20:0] model(input int op, input int a, input int m,
                                          input int imm, input int b, input int bs,
                                          input int src, input int c, input int hc);
        int acc = a, mem = m, wra = 0, wrm = 0, co = c, hco = hc, sk = 0, s, v;
        case (op)
            0: begin acc = (a + m) % 256; wra = 1; end
            1: begin s = a + m + c; acc = s % 256; wra = 1; co = (s > 255);
                     hco = ((a % 16) + (m % 16) + c) > 15; end
            2: begin s = a + (255 - m) + c; acc = s % 256; wra = 1; co = (s > 255);
                     hco = ((a % 16) + (15 - (m % 16)) + c) > 15; end
            3: begin acc = a & m; wra = 1; end
            4: begin acc = a | m; wra = 1; end
            5: begin acc = a ^ m; wra = 1; end
            6: sk = ((a & imm) == 0);
            7: sk = (a != m);
            8: sk = (m != imm);
            9: sk = (a == m);
            10: sk = !(a > m);
            11: sk = (b == (imm % 16));
            12: begin mem = (m + 255) % 256; wrm = 1; sk = (mem == 0); end
            13: begin mem = m | (1 << bs); wrm = 1; end
            14: begin mem = m & (255 - (1 << bs)); wrm = 1; end
            default: begin v = src ? m : a; sk = ((v >> bs) & 1) == 0; end
        endcase
        return {acc[7:0], mem[7:0], wra[0], wrm[0], co[0], hco[0], sk[0]};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic run_op(input int op, input int a, input int m, input int imm,
                          input int b, input int bs, input int src,
                          input int c, input int hc, input string tag);
        logic [20:0] exp;
        in_valid = 1'b1; op_in = op[3:0]; acc_in = a[7:0]; opnd_in = m[7:0];
        imm_in = imm[7:0]; breg_lo_in = b[3:0]; bit_sel = bs[2:0];
        bit_src = src[0]; c_in = c[0]; hc_in = hc[0];
        exp = model(op, a, m, imm, b, bs, src, c, hc);
        @(negedge clk);
        check(tag, $sformatf("op=%0d valid", op), {31'd0, out_valid}, 32'd1);
        check(tag, $sformatf("op=%0d a=%h m=%h {acc,mem,wa,wm,c,hc,sk}", op, a, m),
              {11'd0, res_acc, res_mem, wr_acc, wr_mem, c_out, hc_out, skip_out},
              {11'd0, exp});
    endtask

    task automatic go_idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        in_valid = 1'b1; op_in = 4'd12; opnd_in = 8'h01;
        repeat (3) @(negedge clk);
        // R1
        check("R1", "reset strobes", {28'd0, out_valid, skip_out, wr_acc, wr_mem}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", {30'd0, out_valid, skip_out}, 32'd0);
    endtask

    task automatic t_timing();
        run_op(3, 8'hF0, 8'h3C, 0, 0, 0, 0, 0, 0, "R2");
        run_op(12, 0, 8'h01, 0, 0, 0, 0, 1, 1, "R2");
        go_idle();
        // R2: one cycle only, strobes quiet while idle
        check("R2", "drop after idle", {28'd0, out_valid, skip_out, wr_acc, wr_mem}, 32'd0);
        go_idle();
        check("R2", "stay idle", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_arith();
        run_op(0, 8'hFF, 8'h01, 0, 0, 0, 0, 1, 0, "R3");
        run_op(0, 8'h7F, 8'h80, 0, 0, 0, 0, 0, 1, "R3");
        run_op(1, 8'hFF, 8'h00, 0, 0, 0, 0, 1, 0, "R4");
        run_op(1, 8'h0F, 8'h01, 0, 0, 0, 0, 0, 0, "R4");
        run_op(1, 8'h80, 8'h80, 0, 0, 0, 0, 0, 1, "R4");
        run_op(2, 8'h00, 8'h01, 0, 0, 0, 0, 1, 0, "R5");
        run_op(2, 8'h10, 8'h01, 0, 0, 0, 0, 1, 1, "R5");
        run_op(2, 8'h55, 8'h55, 0, 0, 0, 0, 0, 0, "R5");
        run_op(2, 8'hFF, 8'h00, 0, 0, 0, 0, 1, 0, "R5");
        go_idle();
    endtask

    task automatic t_logic();
        run_op(3, 8'hAA, 8'h0F, 0, 0, 0, 0, 1, 1, "R6");
        run_op(4, 8'hA0, 8'h05, 0, 0, 0, 0, 0, 1, "R6");
        run_op(5, 8'hFF, 8'h5A, 0, 0, 0, 0, 1, 0, "R6");
        run_op(6, 8'hF0, 0, 8'h0F, 0, 0, 0, 0, 0, "R7");
        run_op(6, 8'hF0, 0, 8'h10, 0, 0, 0, 0, 0, "R7");
        go_idle();
    endtask

    task automatic t_compare();
        run_op(7, 8'h42, 8'h42, 0, 0, 0, 0, 0, 0, "R8");
        run_op(7, 8'h42, 8'h43, 0, 0, 0, 0, 0, 0, "R8");
        run_op(9, 8'h42, 8'h42, 0, 0, 0, 0, 0, 0, "R8");
        run_op(9, 8'h00, 8'hFF, 0, 0, 0, 0, 0, 0, "R8");
        run_op(10, 8'h80, 8'h7F, 0, 0, 0, 0, 0, 0, "R8");
        run_op(10, 8'h7F, 8'h7F, 0, 0, 0, 0, 0, 0, "R8");
        run_op(8, 8'h00, 8'h9C, 8'h9C, 0, 0, 0, 0, 0, "R9");
        run_op(8, 8'h9C, 8'h9C, 8'h9D, 0, 0, 0, 0, 0, "R9");
        run_op(11, 0, 0, 8'hF5, 5, 0, 0, 0, 0, "R10");
        run_op(11, 0, 0, 8'h05, 4, 0, 0, 0, 0, "R10");
        go_idle();
    endtask

    task automatic t_bits();
        run_op(12, 8'h33, 8'h01, 0, 0, 0, 0, 0, 0, "R11");
        run_op(12, 8'h33, 8'h00, 0, 0, 0, 0, 1, 1, "R11");
        run_op(12, 8'h33, 8'h80, 0, 0, 0, 0, 0, 0, "R11");
        run_op(13, 0, 8'h00, 0, 0, 7, 0, 0, 0, "R12");
        run_op(13, 0, 8'h10, 0, 0, 4, 0, 0, 0, "R12");
        run_op(14, 0, 8'hFF, 0, 0, 0, 0, 0, 0, "R12");
        run_op(14, 0, 8'hFF, 0, 0, 5, 0, 0, 0, "R12");
        run_op(15, 8'h08, 8'h00, 0, 0, 3, 0, 0, 0, "R13");
        run_op(15, 8'h08, 8'h00, 0, 0, 3, 1, 0, 0, "R13");
        run_op(15, 8'h00, 8'h80, 0, 0, 7, 1, 0, 0, "R13");
        go_idle();
    endtask

    // R14: flags pass through, untouched destinations keep their inputs
    task automatic t_flag_pass();
        for (int op = 3; op < 16; op++)
            run_op(op, 8'hC3, 8'h5A, 8'h21, 9, 2, op & 1, 1, 1, "R14");
        run_op(0, 8'hFF, 8'hFF, 0, 0, 0, 0, 0, 1, "R14");
        go_idle();
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 400; i++) begin
            int a, m, imm, op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[7:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m = lfsr[15:8];
            imm = lfsr[7:0] ^ lfsr[15:8];
            op = i % 16;
            run_op(op, a, m, imm, lfsr[3:0], lfsr[6:4], lfsr[9], lfsr[10], lfsr[11],
                   op2tag(op));
        end
        go_idle();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_timing();
        t_arith();
        t_logic();
        t_compare();
        t_bits();
        t_flag_pass();
        t_sweep();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule